// File: doc/BRIEF.md
# Speculative RAW Violation Detector

This block watches the memory accesses of a small group of tasks that run speculatively in parallel. It flags any access that breaks the sequential order between them. Tasks are ordered by their modular distance from the current oldest task. For each task and each tracked location, the detector keeps two bits:

- a write-seen bit, set when the task writes the location;
- an exposed-read bit, set when the task reads the location before writing it itself.

A write by one task is checked against every task younger than the writer. If a younger task holds an exposed read of that location, the detector produces a one-cycle squash pulse carrying the ID of the oldest such task. In the same step it wipes the tracking state of that task and of every task younger than it.

A build-time parameter selects the tracking grain. With word grain, only a true read-after-write on the same word causes a squash. With line grain, two accesses to different words of one line cannot be told apart. In that mode, false sharing causes squashes, and so does a predecessor writing a line a successor already wrote. Separate commit and abort inputs clear one task's bits. This lets the task ID be reused once that task retires or is restarted.

Top module: `tls_raw_detector`

## Requirements
- R1: A write by task T sets T's write-seen bit for the tracked slot (word in word grain, line in line grain); the write itself never squashes T or any task older than T.
- R2: A read by task T with T's write-seen bit clear sets T's exposed-read bit; a later write to the same word by an older task produces a squash of T.
- R3: A read by T after T itself wrote that slot does not set the exposed-read bit, so a later write by an older task to that word produces no squash in word grain.
- R4: A squash appears as `squash_valid` high for exactly the cycle after the offending write was sampled, with `squash_id` naming the oldest younger task whose bits hit; when several younger tasks hit at once, the one nearest the oldest task is reported.
- R5: A squash clears all bits of the reported task and of every task younger than it in the same clock edge, while tasks older than the reported one keep their bits.
- R6: In word grain, a younger task writing a location an older one read (WAR), writes by two tasks to one word (WAW), and accesses to different words of one line never cause a squash.
- R7: In line grain, an exposed read of any word of a line by a younger task is hit by an older task's write to any word of that line (false sharing squashes).
- R8: In line grain, an older task's write to a line that a younger task has written squashes the younger task (WAW squashes).
- R9: Reads never cause a squash, and a write never squashes a task older than the writer.
- R10: `commit_valid` with `commit_task` = T clears all of T's bits at the next edge, so a following write by an older task finds nothing of T.
- R11: `abort_valid` with `abort_task` = T clears all of T's bits at the next edge in the same way.
- R12: Task age is `(id - oldest_task) mod NUM_TASKS`; ordering wraps, so with `oldest_task` = 2 task 1 is the youngest and task 3 precedes it.
- R13: While `rst_n` is low and after its release, `squash_valid` is 0 and no task holds any bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| oldest_task | input | $clog2(NUM_TASKS) | ID of the current oldest (non-speculative) task |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_task | input | $clog2(NUM_TASKS) | Issuing task ID |
| acc_line | input | $clog2(NUM_LINES) | Tracked line index |
| acc_word | input | $clog2(WORDS_PER_LINE) | Word within the line |
| commit_valid | input | 1 | Clear the bits of a retiring task |
| commit_task | input | $clog2(NUM_TASKS) | Retiring task ID |
| abort_valid | input | 1 | Clear the bits of a task restarted from outside |
| abort_task | input | $clog2(NUM_TASKS) | Restarted task ID |
| squash_valid | output | 1 | One-cycle squash pulse |
| squash_id | output | $clog2(NUM_TASKS) | Oldest violating task; 0 when no pulse |

## Verification
The hardest case to reach is one write hitting several younger readers at once, combined with a wrapped age order. Only this case shows whether the oldest victim is chosen by age rather than by ID, and whether the bits of older tasks survive the squash. The stimulus stages several readers of one word in non-sorted ID order and then writes from the oldest task. A repeated write then shows that every cleared task stays silent. A separate sequence moves `oldest_task` so that ID order and age order disagree. Two instances, one per grain, receive identical traffic, so every false-sharing or WAW case checks the squash in one grain and its absence in the other.

// File: rtl/tls_raw_pkg.sv
package tls_raw_pkg;

    // Tracking grain of the speculative access bits
    typedef enum logic {
        GRAN_LINE = 1'b0,
        GRAN_WORD = 1'b1
    } gran_e;

endpackage

// File: rtl/tls_task_bits.sv
// Per-task write-seen / exposed-read bit store.
module tls_task_bits #(
    parameter int SLOTS = 32,
    localparam int IW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_en,
    input  logic             acc_write,
    input  logic [IW-1:0]    idx,
    input  logic             clr,
    output logic [SLOTS-1:0] sw_o,
    output logic [SLOTS-1:0] er_o
);

    typedef struct packed {
        logic [SLOTS-1:0] sw;
        logic [SLOTS-1:0] er;
    } bits_t;

    bits_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (acc_en) begin
            if (acc_write) begin
                st_d.sw[idx] = 1'b1;
            end else if (!st_q.sw[idx]) begin
                st_d.er[idx] = 1'b1;
            end
        end
        if (clr) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sw_o = st_q.sw;
    assign er_o = st_q.er;

endmodule

// File: rtl/tls_victim_pick.sv
// Picks the oldest hitting task and builds the clear mask for it and its successors.
module tls_victim_pick #(
    parameter int NUM_TASKS = 4,
    localparam int TW       = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1
) (
    input  logic [NUM_TASKS-1:0]    hit,
    input  logic [NUM_TASKS*TW-1:0] age,
    output logic                    found,
    output logic [TW-1:0]           victim,
    output logic [NUM_TASKS-1:0]    kill_mask
);

    logic [TW-1:0] best_age;

    always_comb begin
        found    = 1'b0;
        victim   = '0;
        best_age = '1;
        for (int t = 0; t < NUM_TASKS; t++) begin
            if (hit[t] && (!found || age[t*TW +: TW] < best_age)) begin
                found    = 1'b1;
                victim   = TW'(t);
                best_age = age[t*TW +: TW];
            end
        end
        for (int t = 0; t < NUM_TASKS; t++) begin
            kill_mask[t] = found && (age[t*TW +: TW] >= best_age);
        end
    end

endmodule

// File: rtl/tls_raw_detector.sv
module tls_raw_detector
    import tls_raw_pkg::*;
#(
    parameter int    NUM_TASKS      = 4,
    parameter int    NUM_LINES      = 8,
    parameter int    WORDS_PER_LINE = 4,
    parameter gran_e GRAN           = GRAN_WORD,
    localparam int   TW    = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1,
    localparam int   LW    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int   WW    = (WORDS_PER_LINE > 1) ? $clog2(WORDS_PER_LINE) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] oldest_task,
    input  logic          acc_valid,
    input  logic          acc_write,
    input  logic [TW-1:0] acc_task,
    input  logic [LW-1:0] acc_line,
    input  logic [WW-1:0] acc_word,
    input  logic          commit_valid,
    input  logic [TW-1:0] commit_task,
    input  logic          abort_valid,
    input  logic [TW-1:0] abort_task,
    output logic          squash_valid,
    output logic [TW-1:0] squash_id
);

    localparam bit WORD_MODE = (GRAN == GRAN_WORD);
    localparam int SLOTS     = WORD_MODE ? NUM_LINES * (1 << WW) : NUM_LINES;
    localparam int IW        = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    typedef struct packed {
        logic          valid;
        logic [TW-1:0] id;
    } sq_t;

    sq_t sq_d, sq_q;

    logic [IW-1:0]             idx;
    logic [NUM_TASKS*TW-1:0]   age_flat;
    logic [TW-1:0]             wr_age;
    logic [NUM_TASKS-1:0]      hit;
    logic [NUM_TASKS-1:0]      clr;
    logic [NUM_TASKS-1:0]      kill_mask;
    logic                      found;
    logic [TW-1:0]             victim;
    logic [SLOTS-1:0]          sw_bits [NUM_TASKS];
    logic [SLOTS-1:0]          er_bits [NUM_TASKS];

    // Slot index: word grain keeps line and word, line grain folds words together
    generate
        if (WORD_MODE) begin : g_word_idx
            assign idx = IW'({acc_line, acc_word});
        end else begin : g_line_idx
            assign idx = IW'(acc_line);
        end
    endgenerate

    // Bit stores, one per task
    generate
        for (genvar t = 0; t < NUM_TASKS; t++) begin : g_task
            tls_task_bits #(.SLOTS(SLOTS)) u_bits (
                .clk       (clk),
                .rst_n     (rst_n),
                .acc_en    (acc_valid && (acc_task == TW'(t))),
                .acc_write (acc_write),
                .idx       (idx),
                .clr       (clr[t]),
                .sw_o      (sw_bits[t]),
                .er_o      (er_bits[t])
            );
        end
    endgenerate

    // Age and hit evaluation
    always_comb begin
        wr_age = TW'(acc_task - oldest_task);
        for (int t = 0; t < NUM_TASKS; t++) begin
            logic [TW-1:0] a;
            logic          conflict;
            a = TW'(TW'(t) - oldest_task);
            age_flat[t*TW +: TW] = a;
            conflict = er_bits[t][idx] || (!WORD_MODE && sw_bits[t][idx]);
            hit[t] = acc_valid && acc_write && (a > wr_age) && conflict;
        end
    end

    tls_victim_pick #(.NUM_TASKS(NUM_TASKS)) u_pick (
        .hit       (hit),
        .age       (age_flat),
        .found     (found),
        .victim    (victim),
        .kill_mask (kill_mask)
    );

    // Clear requests and squash pulse
    always_comb begin
        for (int t = 0; t < NUM_TASKS; t++) begin
            clr[t] = (commit_valid && (commit_task == TW'(t)))
                  || (abort_valid  && (abort_task  == TW'(t)))
                  || kill_mask[t];
        end
        sq_d.valid = found;
        sq_d.id    = found ? victim : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_q <= '0;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign squash_valid = sq_q.valid;
    assign squash_id    = sq_q.id;

endmodule

// File: rtl/tls_raw_checker.sv
module tls_raw_checker #(
    parameter int NUM_TASKS = 4,
    localparam int TW       = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [TW-1:0] oldest_task,
    input logic          acc_valid,
    input logic          acc_write,
    input logic [TW-1:0] acc_task,
    input logic          commit_valid,
    input logic [TW-1:0] commit_task,
    input logic          squash_valid,
    input logic [TW-1:0] squash_id
);

    logic          prev_wr;
    logic [TW-1:0] prev_task;
    logic [TW-1:0] prev_oldest;
    logic [TW-1:0] victim_age;
    logic [TW-1:0] writer_age;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_wr     <= 1'b0;
            prev_task   <= '0;
            prev_oldest <= '0;
        end else begin
            prev_wr     <= acc_valid && acc_write;
            prev_task   <= acc_task;
            prev_oldest <= oldest_task;
        end
    end

    assign victim_age = TW'(squash_id - prev_oldest);
    assign writer_age = TW'(prev_task - prev_oldest);

    // R4: a pulse only ever follows a sampled write
    p_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |-> prev_wr);

    // R9: the victim is strictly younger than the writer
    p_younger_victim_r9: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |-> (victim_age > writer_age));

    // R9: a read is never followed by a squash
    p_read_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write) |=> !squash_valid);

    // R10: a committed task cannot be hit by the next write
    p_commit_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && !acc_valid) ##1 (acc_valid && acc_write)
        |=> !(squash_valid && (squash_id == $past(commit_task, 2))));

    // R13: reset keeps the pulse low
    p_reset_quiet_r13: assert property (@(posedge clk)
        !rst_n |=> !squash_valid);

endmodule

bind tls_raw_detector tls_raw_checker #(.NUM_TASKS(NUM_TASKS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .oldest_task  (oldest_task),
    .acc_valid    (acc_valid),
    .acc_write    (acc_write),
    .acc_task     (acc_task),
    .commit_valid (commit_valid),
    .commit_task  (commit_task),
    .squash_valid (squash_valid),
    .squash_id    (squash_id)
);

// File: tb/tls_raw_detector_tb.sv
module tls_raw_detector_tb;
    import tls_raw_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0;
    logic [1:0] oldest_task = '0;
    logic       acc_valid = 1'b0, acc_write = 1'b0;
    logic [1:0] acc_task = '0;
    logic [2:0] acc_line = '0;
    logic [1:0] acc_word = '0;
    logic       commit_valid = 1'b0, abort_valid = 1'b0;
    logic [1:0] commit_task = '0, abort_task = '0;
    logic       w_sv, l_sv;
    logic [1:0] w_sid, l_sid;

    tls_raw_detector #(.GRAN(GRAN_WORD)) u_dut (
        .clk(clk), .rst_n(rst_n), .oldest_task(oldest_task),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_task(acc_task),
        .acc_line(acc_line), .acc_word(acc_word),
        .commit_valid(commit_valid), .commit_task(commit_task),
        .abort_valid(abort_valid), .abort_task(abort_task),
        .squash_valid(w_sv), .squash_id(w_sid));

    tls_raw_detector #(.GRAN(GRAN_LINE)) u_dut_line (
        .clk(clk), .rst_n(rst_n), .oldest_task(oldest_task),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_task(acc_task),
        .acc_line(acc_line), .acc_word(acc_word),
        .commit_valid(commit_valid), .commit_task(commit_task),
        .abort_valid(abort_valid), .abort_task(abort_task),
        .squash_valid(l_sv), .squash_id(l_sid));

    typedef struct {
        logic       ev;
        logic [1:0] et;
        logic       lv;
        logic [1:0] lt;
        string      req;
    } exp_t;

    exp_t q[$];
    exp_t cur;
    int checks = 0;
    int errors = 0;

    task automatic cmp(input string mode, input logic gv, input logic [1:0] gt,
                       input logic ev, input logic [1:0] et, input string req);
        checks++;
        if (gv !== ev || (ev && gt !== et)) begin
            errors++;
            $display("FAIL %s %s: got valid=%0b id=%0d, expected valid=%0b id=%0d",
                     req, mode, gv, gt, ev, et);
        end
    endtask

    // Monitor: compares registered outputs shortly after each edge
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            cur = q.pop_front();
            cmp("word", w_sv, w_sid, cur.ev, cur.et, cur.req);
            cmp("line", l_sv, l_sid, cur.lv, cur.lt, cur.req);
        end
    end

    task automatic push(input logic ev, input logic [1:0] et,
                        input logic lv, input logic [1:0] lt, input string req);
        exp_t e;
        e.ev = ev; e.et = et; e.lv = lv; e.lt = lt; e.req = req;
        q.push_back(e);
    endtask

    task automatic idle_ctl();
        acc_valid = 1'b0;
        commit_valid = 1'b0;
        abort_valid = 1'b0;
    endtask

    task automatic rd(input logic [1:0] t, input logic [2:0] l, input logic [1:0] w,
                      input string req);
        @(negedge clk);
        idle_ctl();
        acc_valid = 1'b1; acc_write = 1'b0;
        acc_task = t; acc_line = l; acc_word = w;
        push(1'b0, 2'd0, 1'b0, 2'd0, req);
    endtask

    task automatic wr(input logic [1:0] t, input logic [2:0] l, input logic [1:0] w,
                      input logic ev, input logic [1:0] et,
                      input logic lv, input logic [1:0] lt, input string req);
        @(negedge clk);
        idle_ctl();
        acc_valid = 1'b1; acc_write = 1'b1;
        acc_task = t; acc_line = l; acc_word = w;
        push(ev, et, lv, lt, req);
    endtask

    task automatic commit(input logic [1:0] t);
        @(negedge clk);
        idle_ctl();
        commit_valid = 1'b1; commit_task = t;
        push(1'b0, 2'd0, 1'b0, 2'd0, "R10");
    endtask

    task automatic abort(input logic [1:0] t);
        @(negedge clk);
        idle_ctl();
        abort_valid = 1'b1; abort_task = t;
        push(1'b0, 2'd0, 1'b0, 2'd0, "R11");
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_ctl();
        rst_n = 1'b0;
        oldest_task = 2'd0;
        @(negedge clk);
        @(negedge clk);
        cmp("word", w_sv, w_sid, 1'b0, 2'd0, "R13");
        cmp("line", l_sv, l_sid, 1'b0, 2'd0, "R13");
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        // R2 R4: exposed read then older write on same word
        rd(2, 1, 0, "R2");
        wr(0, 1, 0, 1'b1, 2'd2, 1'b1, 2'd2, "R2");
        do_reset();
        // R3 R1 R8: own write masks read; line grain sees WAW
        wr(2, 1, 0, 1'b0, 2'd0, 1'b0, 2'd0, "R1");
        rd(2, 1, 0, "R3");
        wr(0, 1, 0, 1'b0, 2'd0, 1'b1, 2'd2, "R3_R8");
        do_reset();
        // R6 R7: false sharing, different words of one line
        rd(2, 3, 1, "R7");
        wr(0, 3, 2, 1'b0, 2'd0, 1'b1, 2'd2, "R6_R7");
        do_reset();
        // R9 R6: younger write after older read (WAR)
        rd(0, 2, 0, "R9");
        wr(3, 2, 0, 1'b0, 2'd0, 1'b0, 2'd0, "R9_WAR");
        do_reset();
        // R4 R5: several readers, oldest reported, all cleared
        rd(3, 4, 3, "R4");
        rd(1, 4, 3, "R4");
        rd(2, 4, 3, "R4");
        wr(0, 4, 3, 1'b1, 2'd1, 1'b1, 2'd1, "R4");
        wr(0, 4, 3, 1'b0, 2'd0, 1'b0, 2'd0, "R5");
        do_reset();
        // R12: wrapped order, oldest is task 2
        oldest_task = 2'd2;
        rd(1, 0, 0, "R12");
        wr(3, 0, 0, 1'b1, 2'd1, 1'b1, 2'd1, "R12");
        rd(2, 5, 0, "R12");
        wr(0, 5, 0, 1'b0, 2'd0, 1'b0, 2'd0, "R12_R9");
        do_reset();
        // R10 R11: commit and abort clear bits
        rd(1, 6, 1, "R10");
        commit(1);
        wr(0, 6, 1, 1'b0, 2'd0, 1'b0, 2'd0, "R10");
        rd(3, 7, 0, "R11");
        abort(3);
        wr(0, 7, 0, 1'b0, 2'd0, 1'b0, 2'd0, "R11");
        do_reset();
        // R6 R8: WAW on one word, older writes after younger
        wr(3, 2, 1, 1'b0, 2'd0, 1'b0, 2'd0, "R1");
        wr(1, 2, 1, 1'b0, 2'd0, 1'b1, 2'd3, "R6_R8");
        do_reset();
        // R5: older tasks keep bits, victim and younger lose them
        rd(1, 3, 3, "R5");
        rd(3, 2, 2, "R5");
        rd(2, 0, 0, "R5");
        wr(1, 0, 0, 1'b1, 2'd2, 1'b1, 2'd2, "R5");
        wr(0, 2, 2, 1'b0, 2'd0, 1'b0, 2'd0, "R5");
        wr(0, 3, 3, 1'b1, 2'd1, 1'b1, 2'd1, "R5");
        @(negedge clk);
        idle_ctl();
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule